// File: doc/BRIEF.md
# DRAM Wake-up and Refresh Sequencer

This block sits on the controller side of an asynchronous fast-page-mode DRAM. It drives the row strobe, column strobe, write enable and output enable, and it multiplexes the address pins. After reset it holds every strobe inactive for a long power-up pause. It then runs a burst of CAS-before-RAS refresh cycles, and only after that burst does it raise `ready`. From then on it issues one CAS-before-RAS refresh per refresh interval. These refreshes rely on the memory's internal row counter, so the controller places no row address on the pins. Host read and write requests are served between refreshes.

A host asserts `hostReq` with `hostWe`, `hostRow` and `hostCol`, and holds all four stable until `hostAck` pulses. The host then drops `hostReq`. While `ready` is low, a request waits and no strobe activity is started for it. The `refHold` input suspends refresh scheduling. If no refresh has completed for the maximum retention time, `ready` falls and the full wake-up burst runs again before any further access. Every duration is a parameter counted in clock cycles.

Top module: `dram_wake_refresh`

## Requirements
- R1: From reset, `rasN`, `casN`, `weN` and `oeN` stay high and `ready` stays low for at least PAUSE_CYC clock cycles; no strobe falls earlier.
- R2: After the pause, exactly WAKE_CYCLES (default 8) refresh cycles are issued before `ready` rises.
- R3: Every refresh is CAS-before-RAS: `casN` falls at least one cycle before `rasN` falls, and `weN` and `oeN` stay high while it runs.
- R4: During a refresh, `dramAddr` is zero when `rasN` falls.
- R5: While `ready` is high and `refHold` is low, consecutive refresh row-strobe falls are at least REF_INT_CYC cycles apart. They are also no further apart than REF_INT_CYC plus one access and one refresh lead-in, even under back-to-back host traffic. A pending refresh wins over a waiting host request, and a cycle in progress is never cut short.
- R6: Before each fall of `casN`, it has been high for at least CP_CYC cycles. Before each fall of `rasN`, it has been high for at least RP_CYC cycles.
- R7: `rasN` stays low for at least RAS_CYC cycles in every cycle type. In an access, `casN` falls exactly RCD_CYC cycles after `rasN` and stays low for at least CAS_CYC cycles.
- R8: For an access, `dramAddr` carries `hostRow` when `rasN` falls and `hostCol` when `casN` falls. For a write (`hostWe`=1), `weN` is already low one cycle before `casN` falls and `oeN` stays high. For a read, `oeN` is low and `weN` high when `casN` falls.
- R9: An access strobe sequence starts only while `ready` is high. A request made while `ready` is low waits. Each accepted request yields exactly one `hostAck` pulse, and it arrives while `ready` is high.
- R10: While `refHold` is high, no new refresh starts. Once TREF_CYC cycles pass without a completed refresh, `ready` falls and the wake-up burst of R2 runs again before `ready` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostReq | input | 1 | Access request, held until `hostAck` |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostRow | input | ADDR_W | Row address of the request |
| hostCol | input | ADDR_W | Column address of the request |
| refHold | input | 1 | Suspends refresh scheduling while high |
| hostAck | output | 1 | One-cycle pulse when the access strobes finish |
| ready | output | 1 | Memory usable; low means requests wait |
| rasN | output | 1 | Row address strobe, active low |
| casN | output | 1 | Column address strobe, active low |
| weN | output | 1 | Write enable, active low |
| oeN | output | 1 | Output enable, active low |
| dramAddr | output | ADDR_W | Multiplexed row/column address |

## Verification
The bench builds the block with a 50-cycle pause, a 60-cycle refresh interval and a 150-cycle retention limit. With RAS 4, CAS 2, RAS-to-CAS 2, row precharge 3, column precharge 2 and CAS-before-RAS setup 1, a full wake-up burst, several refresh intervals under saturating host traffic, and a suspended-refresh overrun followed by a second wake-up all fit in a few thousand cycles. The short strobe widths make exact edge spacing visible, so an off-by-one in any phase counter shifts a measured interval.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  // Timed phases; each selects one reload value for the shared phase timer.
  typedef enum logic [2:0] {
    PH_CSR,
    PH_RAS,
    PH_PRE,
    PH_RCD,
    PH_COL
  } phase_t;

  // Strobes from control to datapath, all active high.
  typedef struct packed {
    logic   ras;
    logic   cas;
    logic   we;
    logic   oe;
    logic   rowSel;
    logic   colSel;
    logic   load;
    phase_t phase;
    logic   refDone;
    logic   wakeInc;
    logic   wakeClr;
  } seqCmd_t;

  function automatic int unsigned maxOf(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_seq_dp.sv
module dram_seq_dp
  import dram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned PAUSE_CYC   = 25000,
  parameter int unsigned RAS_CYC     = 15,
  parameter int unsigned CAS_CYC     = 4,
  parameter int unsigned RCD_CYC     = 5,
  parameter int unsigned RP_CYC      = 10,
  parameter int unsigned CP_CYC      = 3,
  parameter int unsigned CSR_CYC     = 2,
  parameter int unsigned REF_INT_CYC = 3900,
  parameter int unsigned TREF_CYC    = 16000000,
  parameter int unsigned WAKE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqCmd_t           cmd,
  input  logic [ADDR_W-1:0] hostRow,
  input  logic [ADDR_W-1:0] hostCol,
  output logic              timerZero,
  output logic              refPending,
  output logic              overdue,
  output logic              wakeDone,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              oeN,
  output logic [ADDR_W-1:0] dramAddr
);

  localparam int unsigned PRE_LEN = maxOf(RP_CYC, CP_CYC);
  localparam int unsigned COL_LEN = (RAS_CYC > RCD_CYC + CAS_CYC) ? RAS_CYC - RCD_CYC : CAS_CYC;
  localparam int unsigned TMR_MAX = maxOf(PAUSE_CYC, maxOf(maxOf(PRE_LEN, COL_LEN),
                                          maxOf(RAS_CYC, maxOf(RCD_CYC, CSR_CYC))));
  localparam int unsigned TMR_W  = $clog2(TMR_MAX + 1);
  localparam int unsigned REF_W  = $clog2(REF_INT_CYC + 1);
  localparam int unsigned AGE_W  = $clog2(TREF_CYC + 1);
  localparam int unsigned WAKE_W = $clog2(WAKE_CYCLES + 1);
  localparam int unsigned CPC_W  = $clog2(CP_CYC + 1);

  logic [TMR_W-1:0]  timer, loadVal;
  logic [REF_W-1:0]  refCnt;
  logic [AGE_W-1:0]  ageCnt;
  logic [WAKE_W-1:0] wakeCnt;

  // Reload value is the phase length minus one, so a phase lasts its full count.
  always_comb begin
    case (cmd.phase)
      PH_CSR:  loadVal = TMR_W'(CSR_CYC - 1);
      PH_RAS:  loadVal = TMR_W'(RAS_CYC - 1);
      PH_PRE:  loadVal = TMR_W'(PRE_LEN - 1);
      PH_RCD:  loadVal = TMR_W'(RCD_CYC - 1);
      PH_COL:  loadVal = TMR_W'(COL_LEN - 1);
      default: loadVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 timer <= TMR_W'(PAUSE_CYC - 1);
    else if (cmd.load)          timer <= loadVal;
    else if (timer != '0)       timer <= timer - 1'b1;
  end
  assign timerZero = (timer == '0);

  // Refresh interval: request raised REF_INT_CYC cycles after the last refresh.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else if (cmd.refDone) begin
      refCnt     <= '0;
      refPending <= 1'b0;
    end else if (refCnt == REF_W'(REF_INT_CYC - 1)) begin
      refPending <= 1'b1;
    end else begin
      refCnt <= refCnt + 1'b1;
    end
  end

  // Retention age: saturates at TREF_CYC, which flags an overrun.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          ageCnt <= '0;
    else if (cmd.refDone)                ageCnt <= '0;
    else if (ageCnt != AGE_W'(TREF_CYC)) ageCnt <= ageCnt + 1'b1;
  end
  assign overdue = (ageCnt == AGE_W'(TREF_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wakeCnt <= '0;
    else if (cmd.wakeClr) wakeCnt <= '0;
    else if (cmd.wakeInc) wakeCnt <= wakeCnt + 1'b1;
  end
  assign wakeDone = (wakeCnt == WAKE_W'(WAKE_CYCLES));

  // Registered pins: every strobe sees the same one-cycle lag.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rasN     <= 1'b1;
      casN     <= 1'b1;
      weN      <= 1'b1;
      oeN      <= 1'b1;
      dramAddr <= '0;
    end else begin
      rasN     <= ~cmd.ras;
      casN     <= ~cmd.cas;
      weN      <= ~cmd.we;
      oeN      <= ~cmd.oe;
      dramAddr <= cmd.rowSel ? hostRow : (cmd.colSel ? hostCol : '0);
    end
  end

  // Column precharge tracker, used only by the checks below.
  logic [CPC_W-1:0] casHighCnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          casHighCnt <= '0;
    else if (!casN)                      casHighCnt <= '0;
    else if (casHighCnt != CPC_W'(CP_CYC)) casHighCnt <= casHighCnt + 1'b1;
  end

  a_r3_cbr_we_high: assert property (@(posedge clk) disable iff (!rst_n)
    (!casN && $fell(rasN)) |-> (weN && oeN));

  a_r3_cas_leads: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rasN) && !casN) |-> $past(!casN));

  a_r4_cbr_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (!casN && $fell(rasN)) |-> (dramAddr == '0));

  a_r6_cas_precharge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(casN) |-> (casHighCnt >= CPC_W'(CP_CYC)));

endmodule

// File: rtl/dram_seq_ctrl.sv
module dram_seq_ctrl
  import dram_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    hostReq,
  input  logic    hostWe,
  input  logic    refHold,
  input  logic    timerZero,
  input  logic    refPending,
  input  logic    overdue,
  input  logic    wakeDone,
  output seqCmd_t cmd,
  output logic    ready,
  output logic    hostAck
);

  typedef enum logic [2:0] {
    S_PAUSE, S_CSR, S_RAS, S_CPRE, S_IDLE, S_ROW, S_COL, S_APRE
  } state_t;

  state_t state, nextState;
  logic   wakeMode, weLatch, accept;

  always_comb begin
    cmd       = '0;
    nextState = state;
    accept    = 1'b0;
    case (state)
      S_PAUSE: if (timerZero) begin
        nextState = S_CSR; cmd.load = 1'b1; cmd.phase = PH_CSR;
      end
      S_CSR: begin
        cmd.cas = 1'b1;
        if (timerZero) begin nextState = S_RAS; cmd.load = 1'b1; cmd.phase = PH_RAS; end
      end
      S_RAS: begin
        cmd.cas = 1'b1;
        cmd.ras = 1'b1;
        if (timerZero) begin
          nextState   = S_CPRE;
          cmd.load    = 1'b1;
          cmd.phase   = PH_PRE;
          cmd.refDone = 1'b1;
          cmd.wakeInc = wakeMode;
        end
      end
      S_CPRE: if (timerZero) nextState = S_IDLE;
      S_IDLE: begin
        if (wakeMode) begin
          if (!wakeDone) begin nextState = S_CSR; cmd.load = 1'b1; cmd.phase = PH_CSR; end
        end else if (overdue) begin
          cmd.wakeClr = 1'b1;
        end else if (refPending && !refHold) begin
          nextState = S_CSR; cmd.load = 1'b1; cmd.phase = PH_CSR;
        end else if (hostReq) begin
          nextState = S_ROW; cmd.load = 1'b1; cmd.phase = PH_RCD; accept = 1'b1;
        end
      end
      S_ROW: begin
        cmd.ras    = 1'b1;
        cmd.rowSel = 1'b1;
        cmd.we     = weLatch;
        if (timerZero) begin nextState = S_COL; cmd.load = 1'b1; cmd.phase = PH_COL; end
      end
      S_COL: begin
        cmd.ras    = 1'b1;
        cmd.cas    = 1'b1;
        cmd.colSel = 1'b1;
        cmd.we     = weLatch;
        cmd.oe     = ~weLatch;
        if (timerZero) begin nextState = S_APRE; cmd.load = 1'b1; cmd.phase = PH_PRE; end
      end
      S_APRE: if (timerZero) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_PAUSE;
      wakeMode <= 1'b1;
      ready    <= 1'b0;
      weLatch  <= 1'b0;
      hostAck  <= 1'b0;
    end else begin
      state   <= nextState;
      hostAck <= (state == S_COL) && timerZero;
      if (accept) weLatch <= hostWe;
      if (state == S_IDLE && wakeMode && wakeDone) begin
        wakeMode <= 1'b0;
        ready    <= 1'b1;
      end else if (cmd.wakeClr) begin
        wakeMode <= 1'b1;
        ready    <= 1'b0;
      end
    end
  end

  a_r2_ready_after_burst: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> wakeDone);

  a_r9_access_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_ROW) |-> ready);

  a_r9_ack_while_ready: assert property (@(posedge clk) disable iff (!rst_n)
    hostAck |-> ready);

endmodule

// File: rtl/dram_wake_refresh.sv
module dram_wake_refresh
  import dram_seq_pkg::*;
#(
  parameter int unsigned ADDR_W      = 11,
  parameter int unsigned PAUSE_CYC   = 25000,
  parameter int unsigned RAS_CYC     = 15,
  parameter int unsigned CAS_CYC     = 4,
  parameter int unsigned RCD_CYC     = 5,
  parameter int unsigned RP_CYC      = 10,
  parameter int unsigned CP_CYC      = 3,
  parameter int unsigned CSR_CYC     = 2,
  parameter int unsigned REF_INT_CYC = 3900,
  parameter int unsigned TREF_CYC    = 16000000,
  parameter int unsigned WAKE_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostReq,
  input  logic              hostWe,
  input  logic [ADDR_W-1:0] hostRow,
  input  logic [ADDR_W-1:0] hostCol,
  input  logic              refHold,
  output logic              hostAck,
  output logic              ready,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic              oeN,
  output logic [ADDR_W-1:0] dramAddr
);

  seqCmd_t cmd;
  logic    timerZero, refPending, overdue, wakeDone;

  dram_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .hostReq    (hostReq),
    .hostWe     (hostWe),
    .refHold    (refHold),
    .timerZero  (timerZero),
    .refPending (refPending),
    .overdue    (overdue),
    .wakeDone   (wakeDone),
    .cmd        (cmd),
    .ready      (ready),
    .hostAck    (hostAck)
  );

  dram_seq_dp #(
    .ADDR_W      (ADDR_W),
    .PAUSE_CYC   (PAUSE_CYC),
    .RAS_CYC     (RAS_CYC),
    .CAS_CYC     (CAS_CYC),
    .RCD_CYC     (RCD_CYC),
    .RP_CYC      (RP_CYC),
    .CP_CYC      (CP_CYC),
    .CSR_CYC     (CSR_CYC),
    .REF_INT_CYC (REF_INT_CYC),
    .TREF_CYC    (TREF_CYC),
    .WAKE_CYCLES (WAKE_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .hostRow    (hostRow),
    .hostCol    (hostCol),
    .timerZero  (timerZero),
    .refPending (refPending),
    .overdue    (overdue),
    .wakeDone   (wakeDone),
    .rasN       (rasN),
    .casN       (casN),
    .weN        (weN),
    .oeN        (oeN),
    .dramAddr   (dramAddr)
  );

endmodule

// File: tb/dram_wake_refresh_tb.sv
module dram_wake_refresh_tb;

  localparam int AW    = 10;
  localparam int PAUSE = 50;
  localparam int RASC  = 4;
  localparam int CASC  = 2;
  localparam int RCD   = 2;
  localparam int RP    = 3;
  localparam int CP    = 2;
  localparam int CSR   = 1;
  localparam int RINT  = 60;
  localparam int TREF  = 150;
  localparam int WAKE  = 8;
  localparam int GAP_MAX = RINT + 2*RASC + RCD + CASC + RP + CP + CSR + 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic hostReq = 1'b0, hostWe = 1'b0, refHold = 1'b0;
  logic [AW-1:0] hostRow = '0, hostCol = '0;
  logic hostAck, ready, rasN, casN, weN, oeN;
  logic [AW-1:0] dramAddr;

  always #2 clk = ~clk;

  dram_wake_refresh #(
    .ADDR_W(AW), .PAUSE_CYC(PAUSE), .RAS_CYC(RASC), .CAS_CYC(CASC), .RCD_CYC(RCD),
    .RP_CYC(RP), .CP_CYC(CP), .CSR_CYC(CSR), .REF_INT_CYC(RINT), .TREF_CYC(TREF),
    .WAKE_CYCLES(WAKE)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .hostReq(hostReq), .hostWe(hostWe), .hostRow(hostRow),
    .hostCol(hostCol), .refHold(refHold), .hostAck(hostAck), .ready(ready),
    .rasN(rasN), .casN(casN), .weN(weN), .oeN(oeN), .dramAddr(dramAddr)
  );

  int checks = 0, fails = 0;
  logic [2*AW:0] expQ[$];
  int issued = 0, ackCnt = 0, wakeEpisodes = 0, heldCbr = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Monitor: decodes strobe edges, measures widths, pops the scoreboard.
  int cyc = 0, rasHigh = 0, rasLow = 0, casHigh = 0, casLow = 0, accCyc = 0;
  int wakeCbr = 0, lastCbr = 0, holdAge = 0;
  bit pRas = 1, pCas = 1, pWe = 1, pReady = 0, inAcc = 0, lastValid = 0, holdSince = 0, firstSeen = 0;
  logic [AW-1:0] accRow;

  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (inAcc) accCyc++;
      holdAge = refHold ? holdAge + 1 : 0;
      if (!firstSeen && ((pRas && !rasN) || (pCas && !casN))) begin
        firstSeen = 1;
        check(cyc > PAUSE, "R1", "first strobe fall cycle", cyc, PAUSE + 1);
      end
      if (pRas && !rasN) begin
        check(rasHigh >= RP, "R6", "RAS high before fall", rasHigh, RP);
        if (!casN) begin
          check(weN && oeN, "R3", "WE/OE high in refresh", {weN, oeN}, 3);
          check(!pCas, "R3", "CAS led RAS", pCas, 0);
          check(dramAddr == '0, "R4", "refresh address", dramAddr, 0);
          if (holdAge > 3 && ready) heldCbr++;
          if (!ready) wakeCbr++;
          else if (lastValid && !holdSince) begin
            check(cyc - lastCbr >= RINT, "R5", "refresh gap min", cyc - lastCbr, RINT);
            check(cyc - lastCbr <= GAP_MAX, "R5", "refresh gap max", cyc - lastCbr, GAP_MAX);
          end
          lastCbr = cyc; lastValid = ready; holdSince = 0;
        end else begin
          inAcc = 1; accCyc = 0; accRow = dramAddr;
          check(ready, "R9", "access starts only when ready", ready, 1);
        end
      end
      if (pCas && !casN) begin
        check(casHigh >= CP, "R6", "CAS high before fall", casHigh, CP);
        if (inAcc) begin
          check(accCyc == RCD, "R7", "RAS-to-CAS cycles", accCyc, RCD);
          if (expQ.size() == 0) check(0, "R8", "unexpected access", 1, 0);
          else begin
            logic [2*AW:0] exp, act;
            exp = expQ.pop_front();
            act = {~weN, accRow, dramAddr};
            check(act == exp, "R8", "access we/row/col", act, exp);
            if (!weN) check(!pWe && oeN, "R8", "early write WE lead, OE high", {pWe, oeN}, 1);
            else      check(!oeN, "R8", "read OE low", oeN, 0);
          end
        end
      end
      if (!pCas && casN && inAcc) check(casLow >= CASC, "R7", "CAS low width", casLow, CASC);
      if (!pRas && rasN) begin
        check(rasLow >= RASC, "R7", "RAS low width", rasLow, RASC);
        inAcc = 0;
      end
      if (!pReady && ready) begin
        check(wakeCbr == WAKE, "R2", "wake refreshes before ready", wakeCbr, WAKE);
        wakeEpisodes++; wakeCbr = 0;
      end
      if (pReady && !ready) begin lastValid = 0; wakeCbr = 0; end
      if (refHold) holdSince = 1;
      if (hostAck) ackCnt++;
      rasHigh = rasN ? rasHigh + 1 : 0;
      rasLow  = !rasN ? rasLow + 1 : 0;
      casHigh = casN ? casHigh + 1 : 0;
      casLow  = !casN ? casLow + 1 : 0;
      pRas = rasN; pCas = casN; pWe = weN; pReady = ready;
    end
  end

  // Driver: pushes the expected access, then holds the request until acked.
  task automatic doAccess(input bit we, input logic [AW-1:0] row, input logic [AW-1:0] col);
    expQ.push_back({we, row, col});
    issued++;
    @(negedge clk);
    hostReq = 1'b1; hostWe = we; hostRow = row; hostCol = col;
    do @(negedge clk); while (!hostAck);
    check(ready, "R9", "ack while ready", ready, 1);
    hostReq = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check(rasN && casN && weN && oeN, "R1", "strobes idle in reset", {rasN, casN, weN, oeN}, 15);
    check(!ready, "R1", "ready low in reset", ready, 0);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    check(rasN && casN && !ready, "R1", "quiet during pause", {rasN, casN, ready}, 6);
    // R9: request during wake-up waits
    doAccess(1'b1, 10'h2A5, 10'h15A);
    doAccess(1'b0, 10'h2A5, 10'h15A);
    doAccess(1'b1, '0, '1);
    doAccess(1'b0, '1, '0);
    // R5: saturating host traffic, refresh must still win
    for (int i = 0; i < 40; i++) doAccess(i[0], AW'(i * 37), AW'(1000 - i * 11));
    // R10: suspend refresh until retention overrun
    refHold = 1'b1;
    while (ready) @(negedge clk);
    check(!ready, "R10", "ready fell after overrun", ready, 0);
    refHold = 1'b0;
    doAccess(1'b1, 10'h3C3, 10'h0F0);
    check(heldCbr == 0, "R10", "refreshes during hold", heldCbr, 0);
    check(wakeEpisodes == 2, "R10", "wake-up bursts", wakeEpisodes, 2);
    repeat (200) @(negedge clk);
    check(expQ.size() == 0, "R8", "scoreboard drained", expQ.size(), 0);
    check(ackCnt == issued, "R9", "one ack per access", ackCnt, issued);
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      check(0, "R9", "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule